// File: doc/BRIEF.md
# Lane Polarity Inversion Detector

This block sits on one x1 serial lane, after symbol alignment and ahead of the 8b/10b decoder. Each aligned 10-bit line symbol passes through a conditional inverter and a register and goes to the decoder. The decoder's byte and control flag come back into the block, together with a valid strobe that travels with the symbol.

While link training runs, the block tracks the training ordered sets in the decoded stream. Each set opens with a comma control symbol, followed by the identifier symbols. If the differential pair is swapped, every identifier of a set decodes as the complement of the expected code. When a complete set shows this, the block latches one polarity flag for the lane. From then on it complements every bit of every received symbol, so the decoder sees the corrected stream. The flag stays set until the training controller signals a restart, after a reset or after an exit from electrical idle.

Top module: `lanePolarityDetect`

## Requirements
- R1: During and directly after reset, `polInverted` and `symOutValid` are 0.
- R2: `symOut` and `symOutValid` follow `symIn` and `symValid` with one clock of latency. While `polInverted` is 0, the data passes unchanged.
- R3: A set opens with a comma: `decIsK`=1 and byte 0xBC. Positions 1 to 5 follow it, then identifier positions 6 to 15, counting only valid symbols. If all ten identifiers decode as byte 0xB5 with `decIsK`=0 (the complemented first-type training identifier), `polInverted` is 1 one clock after the last identifier appears at the decoder.
- R4: Ten identifiers of byte 0xBA with `decIsK`=0 (the complemented second-type identifier) set the flag in the same way. Cycles where `symValid`=0 may fall between symbols.
- R5: Sets whose identifiers are the normal codes, 0x4A or 0x45, never set the flag.
- R6: A set whose ten identifiers are not all the same complemented code is discarded. This covers a mix of normal and complemented codes, and a mix of the two complemented codes.
- R7: Once `polInverted` is 1, `symOut` is the bitwise complement of the `symIn` of the clock before.
- R8: While `trainActive` is 0, no ordered set can set the flag. The flag changes only through detection or restart.
- R9: A `trainRestart` pulse clears `polInverted` on the next clock. If it coincides with a completed detection, the clear wins.
- R10: A comma that arrives inside a set restarts the position count at 0. Identifiers from the abandoned set do not count toward the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | Aligned symbol present on `symIn` |
| symIn | input | 10 | Aligned 10-bit line symbol |
| trainActive | input | 1 | Link training in progress; enables detection |
| trainRestart | input | 1 | Training restarted (reset or idle exit); clears the flag |
| decByte | input | 8 | Decoder output byte for `symOut` |
| decIsK | input | 1 | Decoder control-symbol flag for `symOut` |
| symOut | output | 10 | Registered, polarity-corrected symbol to the decoder |
| symOutValid | output | 1 | `symOut` valid; qualifies `decByte`/`decIsK` |
| polInverted | output | 1 | Lane polarity found inverted |

## Verification
The flag can be set and cleared in the same clock: the tenth complemented identifier reaches the decoder while `trainRestart` is pulsed. The bench provokes this by raising the restart in exactly the cycle after the last identifier enters the block. It then judges that the flag stays 0 on the next clock and afterwards, so the clear has priority over the set. A detected set followed by a separate restart confirms that each action works on its own.

// File: rtl/lpdPkg.sv
package lpdPkg;
  localparam int SYM_W    = 10;
  localparam int BYTE_W   = 8;
  localparam int NUM_KIND = 2;
  localparam int ID_FIRST = 6;
  localparam int ID_LAST  = 15;

  localparam logic [7:0] COM_BYTE = 8'hBC;

  // complemented identifier byte for each ordered-set kind
  function automatic logic [7:0] invId(input int kind);
    return (kind == 0) ? 8'hB5 : 8'hBA;
  endfunction

  typedef struct packed {
    logic setInv;
    logic clrInv;
  } polStrobe_t;
endpackage

// File: rtl/lpdControl.sv
module lpdControl
  import lpdPkg::*;
#(
  parameter int BYTE_W_P   = BYTE_W,
  parameter int ID_FIRST_P = ID_FIRST,
  parameter int ID_LAST_P  = ID_LAST,
  parameter int NUM_KIND_P = NUM_KIND
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [BYTE_W_P-1:0] decByte,
  input  logic              decIsK,
  input  logic              trainActive,
  input  logic              trainRestart,
  input  logic              polInverted,
  output polStrobe_t        strobe
);
  localparam int IDX_W = $clog2(ID_LAST_P + 1);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(ID_FIRST_P);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ID_LAST_P);

  logic                  inSet;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      nextIdx;
  logic [NUM_KIND_P-1:0] kindVec;
  logic [NUM_KIND_P-1:0] kindNext;
  logic [NUM_KIND_P-1:0] hitVec;
  logic                  isCom;
  logic                  armed;
  logic                  inWindow;

  genvar k;
  generate
    for (k = 0; k < NUM_KIND_P; k++) begin : gKind
      assign hitVec[k] = !decIsK && (decByte == BYTE_W_P'(invId(k)));
    end
  endgenerate

  assign isCom    = decIsK && (decByte == BYTE_W_P'(COM_BYTE));
  assign armed    = trainActive && !polInverted && !trainRestart;
  assign nextIdx  = idx + 1'b1;
  assign inWindow = (nextIdx >= FIRST_IDX) && (nextIdx <= LAST_IDX);

  always_comb begin
    kindNext = kindVec;
    if (nextIdx == FIRST_IDX)
      kindNext = hitVec;
    else if (inWindow)
      kindNext = kindVec & hitVec;
  end

  always_comb begin
    strobe.setInv = armed && decValid && inSet && !isCom &&
                    (nextIdx == LAST_IDX) && (|kindNext);
    strobe.clrInv = trainRestart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSet   <= 1'b0;
      idx     <= '0;
      kindVec <= '0;
    end else if (!armed) begin
      inSet   <= 1'b0;
      idx     <= '0;
      kindVec <= '0;
    end else if (decValid) begin
      if (isCom) begin
        inSet   <= 1'b1;
        idx     <= '0;
        kindVec <= '0;
      end else if (inSet) begin
        idx     <= nextIdx;
        kindVec <= kindNext;
        if (nextIdx == LAST_IDX) inSet <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpdDatapath.sv
module lpdDatapath
  import lpdPkg::*;
#(
  parameter int SYM_W_P = SYM_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               symValid,
  input  logic [SYM_W_P-1:0] symIn,
  input  polStrobe_t         strobe,
  output logic [SYM_W_P-1:0] symOut,
  output logic               symOutValid,
  output logic               polInverted
);
  logic [SYM_W_P-1:0] corrected;

  genvar b;
  generate
    for (b = 0; b < SYM_W_P; b++) begin : gInv
      assign corrected[b] = symIn[b] ^ polInverted;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) polInverted <= 1'b0;
    else if (strobe.clrInv) polInverted <= 1'b0;
    else if (strobe.setInv) polInverted <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symOut      <= '0;
      symOutValid <= 1'b0;
    end else begin
      symOutValid <= symValid;
      if (symValid) symOut <= corrected;
    end
  end
endmodule

// File: rtl/lanePolarityDetect.sv
module lanePolarityDetect
  import lpdPkg::*;
#(
  parameter int SYM_W_P  = SYM_W,
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                symValid,
  input  logic [SYM_W_P-1:0]  symIn,
  input  logic                trainActive,
  input  logic                trainRestart,
  input  logic [BYTE_W_P-1:0] decByte,
  input  logic                decIsK,
  output logic [SYM_W_P-1:0]  symOut,
  output logic                symOutValid,
  output logic                polInverted
);
  polStrobe_t strobe;

  lpdControl #(
    .BYTE_W_P(BYTE_W_P), .ID_FIRST_P(ID_FIRST),
    .ID_LAST_P(ID_LAST), .NUM_KIND_P(NUM_KIND)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .decValid(symOutValid), .decByte(decByte),
    .decIsK(decIsK), .trainActive(trainActive), .trainRestart(trainRestart),
    .polInverted(polInverted), .strobe(strobe)
  );

  lpdDatapath #(.SYM_W_P(SYM_W_P)) uPath (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symIn(symIn),
    .strobe(strobe), .symOut(symOut), .symOutValid(symOutValid),
    .polInverted(polInverted)
  );
endmodule

// File: rtl/lpdChecker.sv
module lpdChecker #(
  parameter int SYM_W_P  = 10,
  parameter int BYTE_W_P = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                symValid,
  input logic [SYM_W_P-1:0]  symIn,
  input logic                trainActive,
  input logic                trainRestart,
  input logic [BYTE_W_P-1:0] decByte,
  input logic                decIsK,
  input logic [SYM_W_P-1:0]  symOut,
  input logic                symOutValid,
  input logic                polInverted
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!polInverted && !symOutValid));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (symOutValid == $past(symValid)));

  // R7
  data_polarity_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(symValid)) |->
      (symOut == ($past(symIn) ^ {SYM_W_P{$past(polInverted)}})));

  // R8
  set_needs_training_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(polInverted) |-> ($past(trainActive) && !$past(trainRestart)));

  // R8
  clear_needs_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(polInverted) |-> $past(trainRestart));

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    trainRestart |=> !polInverted);
endmodule

bind lanePolarityDetect lpdChecker #(.SYM_W_P(SYM_W_P), .BYTE_W_P(BYTE_W_P)) chk (.*);

// File: tb/lanePolarityDetect_test.sv
module lanePolarityDetect_test;
  localparam logic [9:0] COM_N = 10'h0FA, COM_P = 10'h305;
  localparam logic [9:0] PAD   = 10'h3A8;
  localparam logic [9:0] T1_OK = 10'h155, T1_INV = 10'h2AA;
  localparam logic [9:0] T2_OK = 10'h295, T2_INV = 10'h16A;

  logic clk = 0, rstN = 0, symValid = 0, trainActive = 0, trainRestart = 0;
  logic [9:0] symIn = '0, symOut;
  logic [7:0] decByte;
  logic decIsK, symOutValid, polInverted;
  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  lanePolarityDetect uut (.*);

  // minimal decoder model for the codes the bench uses
  always_comb begin
    decIsK = 1'b0;
    case (symOut)
      10'h0FA, 10'h305: begin decByte = 8'hBC; decIsK = 1'b1; end
      10'h3A8, 10'h057: begin decByte = 8'hF7; decIsK = 1'b1; end
      10'h155: decByte = 8'h4A;
      10'h2AA: decByte = 8'hB5;
      10'h295: decByte = 8'h45;
      10'h16A: decByte = 8'hBA;
      default: decByte = 8'h00;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendSym(input logic [9:0] c);
    @(negedge clk); symValid = 1; symIn = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); symValid = 0; end
  endtask

  task automatic sendSet(input logic [9:0] com, input logic [9:0] id,
                         input int mixPos, input logic [9:0] mixCode, input bit gaps);
    sendSym(com);
    for (int p = 1; p <= 5; p++) sendSym(PAD);
    for (int p = 6; p <= 15; p++) begin
      if (gaps) idle(1);
      sendSym(p == mixPos ? mixCode : id);
    end
  endtask

  task automatic clearFlag(input string req);
    @(negedge clk); symValid = 0; trainRestart = 1;
    @(negedge clk); trainRestart = 0;
    chk(req, polInverted, 0);
  endtask

  task automatic testReset();
    chk("R1 flag in reset", polInverted, 0);
    chk("R1 valid in reset", symOutValid, 0);
    @(negedge clk); rstN = 1; trainActive = 1;
    @(negedge clk);
    chk("R1 flag after reset", polInverted, 0);
  endtask

  task automatic testPassThrough();
    sendSym(10'h123);
    idle(1);
    chk("R2 data", symOut, 10'h123);
    chk("R2 valid", symOutValid, 1);
    idle(1);
    chk("R2 valid drop", symOutValid, 0);
  endtask

  task automatic testNormal();
    sendSet(COM_N, T1_OK, 0, 0, 0); idle(2);
    chk("R5 normal TS1", polInverted, 0);
    sendSet(COM_P, T2_OK, 0, 0, 0); idle(2);
    chk("R5 normal TS2", polInverted, 0);
  endtask

  task automatic testMixed();
    sendSet(COM_N, T1_INV, 10, T1_OK, 0); idle(2);
    chk("R6 inv/normal mix", polInverted, 0);
    sendSet(COM_N, T1_INV, 15, T2_INV, 0); idle(2);
    chk("R6 two-kind mix", polInverted, 0);
  endtask

  task automatic testNotTraining();
    @(negedge clk); trainActive = 0;
    sendSet(COM_N, T1_INV, 0, 0, 0); idle(2);
    chk("R8 idle training", polInverted, 0);
    @(negedge clk); trainActive = 1;
  endtask

  task automatic testComRestart();
    sendSym(COM_N);
    for (int p = 1; p <= 5; p++) sendSym(PAD);
    for (int p = 0; p < 4; p++) sendSym(T1_INV);
    sendSym(COM_N);
    for (int p = 0; p < 6; p++) sendSym(T1_INV);
    idle(3);
    chk("R10 comma restarts count", polInverted, 0);
  endtask

  task automatic testTs1Detect();
    sendSet(COM_N, T1_INV, 0, 0, 0);
    idle(1);
    chk("R3 not before last id decoded", polInverted, 0);
    idle(1);
    chk("R3 TS1 inverted sets flag", polInverted, 1);
    sendSym(T1_INV); idle(1);
    chk("R7 data complemented", symOut, T1_OK);
    chk("R7 decoder restored", decByte, 8'h4A);
    sendSym(COM_N); idle(1);
    chk("R7 comma complemented", symOut, COM_P);
    idle(5);
    chk("R8 flag held", polInverted, 1);
    clearFlag("R9 restart clears");
  endtask

  task automatic testTs2Detect();
    sendSet(COM_P, T2_INV, 0, 0, 1); idle(2);
    chk("R4 TS2 inverted with gaps", polInverted, 1);
    clearFlag("R9 restart clears TS2");
  endtask

  task automatic testCollision();
    sendSet(COM_N, T1_INV, 0, 0, 0);
    @(negedge clk); symValid = 0; trainRestart = 1;
    @(negedge clk); trainRestart = 0;
    chk("R9 clear wins over set", polInverted, 0);
    idle(2);
    chk("R9 stays clear", polInverted, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testPassThrough();
    testNormal();
    testMixed();
    testNotTraining();
    testComRestart();
    testTs1Detect();
    testTs2Detect();
    testCollision();
    idle(2);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule